// File: doc/BRIEF.md
# Per-Core Countdown Timer with Prescaler

This block is a 32-bit down-counter that raises a level interrupt when its count runs out. One copy is placed next to each processor core. Software reaches it through a small word-access register port with four registers: a reload value, the live count, a control word and a sticky event flag. The counter decrements once every (P+1) clocks, where P is an 8-bit prescale value held in the control word. In one-shot mode the counter stops when it expires. In periodic mode it reloads and keeps running. Several zero-value cases stop the counter instead of producing an event, so software can halt the timer by writing zero.

The counting engine is a two-state machine. The states are ST_STOP (idle) and ST_RUN (counting). There are four transitions. START moves ST_STOP to ST_RUN when a register write leaves the block enabled and either P or the effective count is nonzero. HALT moves ST_RUN to ST_STOP on a write that clears enable or that zeroes the count. EXPIRE_RELOAD keeps ST_RUN in periodic mode and loads the reload value. EXPIRE_HALT moves ST_RUN to ST_STOP in one-shot mode, or in periodic mode when both the reload value and P are zero.

Top module: `tmr_private`

## Requirements
- R1: After reset, the reload value, the count, the control word and the event flag all read zero, `irq_o` is low and the counter is stopped.
- R2: The byte offsets are 0x0 (reload value), 0x4 (count), 0x8 (control) and 0xC (event flag, bit 0). The control bits are bit 0 enable, bit 1 periodic, bit 2 interrupt enable, and bits 15:8 the prescale value P. Control bits not listed read zero. Any other offset, including one with address bits 1:0 nonzero, reads zero and ignores writes.
- R3: While running, the count drops by one at every (P+1)-th clock edge. The first drop comes P+1 edges after the write that started the counter. A write to offset 0x0, 0x4 or 0x8 restarts the prescale phase.
- R4: `irq_o` is high exactly when the event flag is set and interrupt enable is set.
- R5: Expiry happens on a decrement step that finds the count at 1, or at 0 when P is nonzero. Expiry sets the event flag. In one-shot mode the count then stays at 0 and the counter stops.
- R6: In periodic mode, expiry reloads the count from the reload value and counting continues, so events repeat every reload × (P+1) clocks.
- R7: A write to the reload value also copies it into the count. The counter runs only when enable is set and either P or the value being counted is nonzero.
- R8: With the block enabled and P zero, each of these stops the counter and raises no event: writing 0 to the reload value; writing 0 to the count in one-shot mode; writing 0 to the count in periodic mode while the reload value is 0. Writing 0 to the count in periodic mode with a nonzero reload value loads the reload value instead.
- R9: A control write that clears enable freezes the count. A control write that enables periodic mode while the count is 0 first loads the reload value into the count.
- R10: In periodic mode with a reload value of 0, expiry stops the counter when P is 0. When P is nonzero, an event is raised every P+1 clocks.
- R11: Writing the event flag clears bit 0 if the written bit 0 is 1 and has no effect if it is 0. If an expiry happens in the same cycle as a clear, the flag stays set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Timer and register clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en_i | input | 1 | Write strobe for the register port |
| addr_i | input | ADDR_W (5) | Byte address of the register |
| wdata_i | input | DATA_W (32) | Write data |
| rdata_o | output | DATA_W (32) | Read data, combinational from `addr_i` |
| irq_o | output | 1 | Level interrupt |

## Verification
The scoreboard predicts the edge at which the interrupt rises, computed from the starting write's cycle, the reload value and P. This is tried for one-shot with P=0, periodic with P=3 and periodic with P=1 and a reload value of zero; the three cases separate decrement-per-clock from decrement-per-period and reload from halt. Reads of the count at known offsets from the starting write pin the prescale phase. Zero writes to the reload value and to the count, in each mode, separate a silent stop from an expiry. A clear timed against a live periodic tick shows which of set and clear wins.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int PRE_W = 8;

    typedef enum logic {
        ST_STOP = 1'b0,
        ST_RUN  = 1'b1
    } tmr_state_e;

    typedef enum logic [1:0] {
        CMD_NONE  = 2'd0,
        CMD_LOAD  = 2'd1,
        CMD_COUNT = 2'd2,
        CMD_CTRL  = 2'd3
    } tmr_cmd_e;

    typedef struct packed {
        logic [PRE_W-1:0] presc;
        logic             irq_en;
        logic             periodic;
        logic             enable;
    } tmr_ctrl_t;

    localparam logic [1:0] IDX_LOAD  = 2'd0;
    localparam logic [1:0] IDX_COUNT = 2'd1;
    localparam logic [1:0] IDX_CTRL  = 2'd2;
    localparam logic [1:0] IDX_FLAG  = 2'd3;

endpackage

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
    parameter int PRE_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             run_i,
    input  logic             clear_i,
    input  logic [PRE_W-1:0] ratio_i,
    output logic             tick_o
);

    logic [PRE_W-1:0] phase_q;
    logic             wrap;

    assign wrap   = (phase_q == ratio_i);
    assign tick_o = run_i && !clear_i && wrap;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= '0;
        end else if (!run_i || clear_i || wrap) begin
            phase_q <= '0;
        end else begin
            phase_q <= phase_q + 1'b1;
        end
    end

endmodule

// File: rtl/tmr_counter.sv
module tmr_counter
    import tmr_pkg::*;
#(
    parameter int CW = 32
) (
    input  logic             clk,
    input  logic             rst_n,
    input  tmr_cmd_e         cmd_i,
    input  logic [CW-1:0]    wval_i,
    input  logic             cur_en_i,
    input  logic             cur_per_i,
    input  logic [PRE_W-1:0] cur_presc_i,
    input  logic             new_en_i,
    input  logic             new_per_i,
    input  logic [PRE_W-1:0] new_presc_i,
    input  logic [CW-1:0]    load_i,
    input  logic             tick_i,
    output logic [CW-1:0]    count_o,
    output logic             running_o,
    output logic             expire_o
);

    tmr_state_e    state_q, state_d;
    logic [CW-1:0] count_q, count_d;
    logic [CW-1:0] eff;
    logic          expire;
    logic          cur_pre_zero;

    assign cur_pre_zero = (cur_presc_i == '0);

    always_comb begin
        state_d = state_q;
        count_d = count_q;
        expire  = 1'b0;
        eff     = count_q;
        unique case (cmd_i)
            CMD_LOAD: begin
                count_d = wval_i;
                if (cur_en_i) begin
                    state_d = (!cur_pre_zero || wval_i != '0) ? ST_RUN : ST_STOP;
                end
            end
            CMD_COUNT: begin
                eff = (cur_en_i && cur_per_i && cur_pre_zero && wval_i == '0)
                      ? load_i : wval_i;
                count_d = eff;
                if (cur_en_i) begin
                    state_d = (!cur_pre_zero || eff != '0) ? ST_RUN : ST_STOP;
                end
            end
            CMD_CTRL: begin
                eff = (new_per_i && count_q == '0) ? load_i : count_q;
                if (new_en_i) begin
                    count_d = eff;
                end
                state_d = (new_en_i && (new_presc_i != '0 || eff != '0))
                          ? ST_RUN : ST_STOP;
            end
            default: begin
                unique case (state_q)
                    ST_STOP: ;
                    ST_RUN: begin
                        if (tick_i) begin
                            if (count_q > CW'(1)) begin
                                count_d = count_q - CW'(1);
                            end else begin
                                expire = 1'b1;
                                if (cur_per_i) begin
                                    count_d = load_i;
                                    if (load_i == '0 && cur_pre_zero) begin
                                        state_d = ST_STOP;
                                    end
                                end else begin
                                    count_d = '0;
                                    state_d = ST_STOP;
                                end
                            end
                        end
                    end
                endcase
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_STOP;
            count_q <= '0;
        end else begin
            state_q <= state_d;
            count_q <= count_d;
        end
    end

    always_comb begin
        count_o   = count_q;
        running_o = (state_q == ST_RUN);
        expire_o  = expire;
    end

endmodule

// File: rtl/tmr_private.sv
module tmr_private
    import tmr_pkg::*;
#(
    parameter int DATA_W = 32,
    parameter int ADDR_W = 5
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] addr_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [DATA_W-1:0] rdata_o,
    output logic              irq_o
);

    localparam int IDX_W = ADDR_W - 2;

    logic [IDX_W-1:0]  idx;
    logic              in_map;
    logic [1:0]        sel;
    tmr_cmd_e          cmd;
    logic              cnt_cmd;
    logic              flag_wr;
    tmr_ctrl_t         ctrl_q, ctrl_new;
    logic [DATA_W-1:0] load_q;
    logic              status_q;
    logic [DATA_W-1:0] count_w;
    logic              running_w;
    logic              tick_w;
    logic              expire_w;

    assign idx    = addr_i[ADDR_W-1:2];
    assign in_map = (addr_i[1:0] == 2'b00) && (idx < IDX_W'(4));
    assign sel    = idx[1:0];

    assign ctrl_new.presc    = wdata_i[8 +: PRE_W];
    assign ctrl_new.irq_en   = wdata_i[2];
    assign ctrl_new.periodic = wdata_i[1];
    assign ctrl_new.enable   = wdata_i[0];

    always_comb begin
        cmd     = CMD_NONE;
        flag_wr = 1'b0;
        if (wr_en_i && in_map) begin
            unique case (sel)
                IDX_LOAD:  cmd = CMD_LOAD;
                IDX_COUNT: cmd = CMD_COUNT;
                IDX_CTRL:  cmd = CMD_CTRL;
                IDX_FLAG:  flag_wr = 1'b1;
            endcase
        end
    end

    assign cnt_cmd = (cmd != CMD_NONE);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            load_q   <= '0;
            ctrl_q   <= '0;
            status_q <= 1'b0;
        end else begin
            if (cmd == CMD_LOAD) load_q <= wdata_i;
            if (cmd == CMD_CTRL) ctrl_q <= ctrl_new;
            if (expire_w) begin
                status_q <= 1'b1;
            end else if (flag_wr && wdata_i[0]) begin
                status_q <= 1'b0;
            end
        end
    end

    tmr_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk     (clk),
        .rst_n   (rst_n),
        .run_i   (running_w),
        .clear_i (cnt_cmd),
        .ratio_i (ctrl_q.presc),
        .tick_o  (tick_w)
    );

    tmr_counter #(.CW(DATA_W)) u_cnt (
        .clk         (clk),
        .rst_n       (rst_n),
        .cmd_i       (cmd),
        .wval_i      (wdata_i),
        .cur_en_i    (ctrl_q.enable),
        .cur_per_i   (ctrl_q.periodic),
        .cur_presc_i (ctrl_q.presc),
        .new_en_i    (ctrl_new.enable),
        .new_per_i   (ctrl_new.periodic),
        .new_presc_i (ctrl_new.presc),
        .load_i      (load_q),
        .tick_i      (tick_w),
        .count_o     (count_w),
        .running_o   (running_w),
        .expire_o    (expire_w)
    );

    always_comb begin
        rdata_o = '0;
        if (in_map) begin
            unique case (sel)
                IDX_LOAD:  rdata_o = load_q;
                IDX_COUNT: rdata_o = count_w;
                IDX_CTRL:  rdata_o = DATA_W'({ctrl_q.presc, 5'b00000, ctrl_q.irq_en,
                                              ctrl_q.periodic, ctrl_q.enable});
                IDX_FLAG:  rdata_o = DATA_W'(status_q);
            endcase
        end
    end

    assign irq_o = status_q && ctrl_q.irq_en;

endmodule

// File: rtl/tmr_private_chk.sv
module tmr_private_chk #(
    parameter int CW = 32
) (
    input logic          clk,
    input logic          rst_n,
    input logic          cnt_cmd,
    input logic          tick,
    input logic          running,
    input logic [CW-1:0] count,
    input logic [CW-1:0] load,
    input logic          status,
    input logic          periodic,
    input logic          irq_en,
    input logic          irq
);

    a_r3_step: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cnt_cmd && count > CW'(1)) |=> count == $past(count) - CW'(1));

    a_r5_flag_set: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cnt_cmd && count <= CW'(1)) |=> status);

    a_r5_oneshot_halt: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cnt_cmd && count <= CW'(1) && !periodic)
        |=> (!running && count == '0));

    a_r6_reload: assert property (@(posedge clk) disable iff (!rst_n)
        (running && tick && !cnt_cmd && count <= CW'(1) && periodic)
        |=> count == $past(load));

    a_r9_frozen: assert property (@(posedge clk) disable iff (!rst_n)
        (!running && !cnt_cmd) |=> $stable(count));

    a_r4_mask: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    a_r4_needs_flag: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> status);

endmodule

bind tmr_private tmr_private_chk u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .cnt_cmd  (cnt_cmd),
    .tick     (tick_w),
    .running  (running_w),
    .count    (count_w),
    .load     (load_q),
    .status   (status_q),
    .periodic (ctrl_q.periodic),
    .irq_en   (ctrl_q.irq_en),
    .irq      (irq_o)
);

// File: tb/tmr_private_tb.sv
`timescale 1ns/1ps
module tmr_private_tb;

    localparam int DW = 32;
    localparam int AW = 5;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_en = 1'b0;
    logic [AW-1:0] addr = '0;
    logic [DW-1:0] wdata = '0;
    logic [DW-1:0] rdata;
    logic          irq;

    always #2.5 clk = ~clk;

    tmr_private u_dut (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en_i (wr_en),
        .addr_i  (addr),
        .wdata_i (wdata),
        .rdata_o (rdata),
        .irq_o   (irq)
    );

    int cyc = 0;
    always @(posedge clk) cyc <= cyc + 1;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    typedef struct {
        int    at;
        logic  val;
        string tag;
    } exp_t;
    exp_t sbq[$];

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h (cycle %0d)", tag, act, exp, cyc);
        end
    endtask

    task automatic expect_irq(input int at, input logic v, input string tag);
        exp_t e;
        e.at = at; e.val = v; e.tag = tag;
        sbq.push_back(e);
    endtask

    // monitor: pops expected interrupt levels at their cycle
    initial begin
        forever begin
            @(negedge clk);
            while (sbq.size() > 0 && sbq[0].at <= cyc) begin
                exp_t e;
                e = sbq.pop_front();
                if (e.at == cyc) check(e.tag, {31'b0, irq}, {31'b0, e.val});
                else             check({e.tag, " missed"}, 32'd0, 32'd1);
            end
        end
    end

    task automatic wr(input logic [AW-1:0] a, input logic [31:0] d, output int cw);
        @(negedge clk);
        addr = a; wdata = d; wr_en = 1'b1;
        @(negedge clk);
        wr_en = 1'b0;
        cw = cyc;
    endtask

    task automatic rd(input logic [AW-1:0] a, output logic [31:0] d, output int at);
        @(negedge clk);
        addr = a;
        #1;
        d  = rdata;
        at = cyc;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wait_until(input int c);
        while (cyc < c) @(negedge clk);
    endtask

    task automatic summary;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!done) begin
            n_chk++; n_fail++;
            $display("FAIL watchdog: actual hung expected finish");
            summary();
            $finish;
        end
    end

    initial begin
        int cw, cw2, at, a1, a2;
        logic [31:0] d, d2;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1: reset state
        rd(5'h00, d, at); check("R1 load", d, 0);
        rd(5'h04, d, at); check("R1 count", d, 0);
        rd(5'h08, d, at); check("R1 ctrl", d, 0);
        rd(5'h0C, d, at); check("R1 flag", d, 0);
        check("R1 irq", {31'b0, irq}, 0);

        // R2: control field layout and unmapped offsets
        wr(5'h08, 32'hFFFF_FFF8, cw);
        rd(5'h08, d, at); check("R2 ctrl bits", d, 32'h0000_FF00);
        wr(5'h08, 32'h0, cw);
        wr(5'h10, 32'hDEAD_BEEF, cw);
        wr(5'h01, 32'h0000_0077, cw);
        rd(5'h10, d, at); check("R2 unmapped read", d, 0);
        rd(5'h02, d, at); check("R2 misaligned read", d, 0);
        rd(5'h00, d, at); check("R2 load untouched", d, 0);

        // R7: enabled with everything zero does not run
        wr(5'h08, 32'h5, cw);
        idle(3);
        rd(5'h0C, d, at); check("R7 no run on zero", d, 0);

        // R3/R5/R7: one-shot, P=0, load 5
        wr(5'h00, 32'd5, cw);
        expect_irq(cw + 4, 1'b0, "R5 before expiry");
        expect_irq(cw + 5, 1'b1, "R5 at expiry");
        rd(5'h04, d, at); check("R7 R3 count P0", d, 5 - (at - cw));
        wait_until(cw + 12);
        rd(5'h04, d, at); check("R5 oneshot stays 0", d, 0);
        rd(5'h0C, d, at); check("R5 flag set", d, 1);

        // R11: write-one-to-clear
        wr(5'h0C, 32'h0, cw);
        rd(5'h0C, d, at); check("R11 write 0 keeps", d, 1);
        wr(5'h0C, 32'h1, cw);
        rd(5'h0C, d, at); check("R11 write 1 clears", d, 0);
        check("R4 irq follows clear", {31'b0, irq}, 0);

        // R4: interrupt masked by irq enable
        wr(5'h08, 32'h1, cw);
        wr(5'h00, 32'd2, cw);
        idle(4);
        rd(5'h0C, d, at); check("R4 flag set unmasked", d, 1);
        check("R4 irq masked", {31'b0, irq}, 0);
        wr(5'h08, 32'h5, cw);
        check("R4 irq unmasked", {31'b0, irq}, 1);
        wr(5'h0C, 32'h1, cw);

        // R3/R6: periodic, P=3, load 4
        wr(5'h08, 32'h0, cw);
        wr(5'h00, 32'd4, cw);
        wr(5'h08, 32'h0307, cw);
        expect_irq(cw + 15, 1'b0, "R6 first period low");
        expect_irq(cw + 16, 1'b1, "R6 first expiry");
        rd(5'h04, d, at); check("R3 count P3 a", d, 4 - (at - cw) / 4);
        idle(5);
        rd(5'h04, d, at); check("R3 count P3 b", d, 4 - (at - cw) / 4);
        wait_until(cw + 18);
        wr(5'h0C, 32'h1, cw2);
        expect_irq(cw + 31, 1'b0, "R6 second period low");
        expect_irq(cw + 32, 1'b1, "R6 reload expiry");
        wait_until(cw + 34);
        wr(5'h08, 32'h0, cw2);
        wr(5'h0C, 32'h1, cw2);

        // R9: clearing enable freezes count
        wr(5'h08, 32'h1, cw);
        wr(5'h00, 32'd100, cw);
        idle(5);
        wr(5'h08, 32'h0, cw2);
        rd(5'h04, d, a1);
        idle(5);
        rd(5'h04, d2, a2);
        check("R9 frozen value", d, 100 - (cw2 - 1 - cw));
        check("R9 frozen stable", d2, d);

        // R8: zero reload write stops without event
        wr(5'h08, 32'h5, cw);
        idle(3);
        wr(5'h00, 32'd0, cw);
        idle(10);
        rd(5'h0C, d, at); check("R8 zero load no event", d, 0);
        rd(5'h04, d, at); check("R8 zero load count", d, 0);

        // R8: zero count write in one-shot
        wr(5'h00, 32'd50, cw);
        idle(3);
        wr(5'h04, 32'd0, cw);
        idle(60);
        rd(5'h0C, d, at); check("R8 zero count oneshot", d, 0);

        // R8: zero count write in periodic with reload nonzero
        wr(5'h08, 32'h7, cw);
        wr(5'h00, 32'd6, cw);
        wr(5'h04, 32'd0, cw);
        rd(5'h04, d, at); check("R8 periodic zero reloads", d, 6 - (at - cw));
        wr(5'h08, 32'h0, cw);
        wr(5'h0C, 32'h1, cw);

        // R9/R10: periodic, load 0, P=0
        wr(5'h00, 32'd0, cw);
        wr(5'h08, 32'h7, cw);
        idle(3);
        rd(5'h0C, d, at); check("R9 periodic enable zero stays", d, 0);
        wr(5'h04, 32'd3, cw);
        expect_irq(cw + 3, 1'b1, "R10 expiry P0 load0");
        wait_until(cw + 5);
        wr(5'h0C, 32'h1, cw);
        idle(10);
        rd(5'h0C, d, at); check("R10 stops after expiry", d, 0);
        rd(5'h04, d, at); check("R10 count zero", d, 0);

        // R10/R11: periodic, load 0, P=1 -> event every 2 clocks
        wr(5'h08, 32'h0, cw);
        wr(5'h08, 32'h0107, cw);
        expect_irq(cw + 1, 1'b0, "R10 before first tick");
        expect_irq(cw + 2, 1'b1, "R10 first tick event");
        wait_until(cw + 3);
        wr(5'h0C, 32'h1, cw2);
        if (((cw2 - cw) % 2) == 0) begin
            check("R11 set wins over clear", {31'b0, irq}, 1);
            expect_irq(cw2 + 2, 1'b1, "R10 repeats");
        end else begin
            check("R11 clear between ticks", {31'b0, irq}, 0);
            expect_irq(cw2 + 1, 1'b1, "R10 repeats");
        end
        idle(4);
        wr(5'h08, 32'h0, cw);
        wr(5'h0C, 32'h1, cw);
        rd(5'h0C, d, at); check("R11 final clear", d, 0);

        idle(3);
        done = 1;
        summary();
        $finish;
    end

endmodule